// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a progressive video raster from a single pixel clock. Two counters walk the frame. Their origin is the first visible pixel of the first visible line, so the X and Y outputs are the visible coordinates. The X output can drive the read address of a line buffer without any offset. An active-video flag, a horizontal sync and a vertical sync come with the coordinates, and every one of these outputs is driven from a flip-flop.

The frame format lives in eight registers, which are written through an address, data and write-enable port. Each boundary is the value that a counter is compared against for equality, so no arithmetic sits in the compare path. A write goes first into a staging copy. The staging copy is moved into the live copy only when both counters wrap to the frame origin, so software can change the mode while the raster runs and no frame is ever built from two formats.

Each sync has its own polarity input. The vertical sync is re-timed so that it only changes at a leading edge of the horizontal sync. An external frame pulse can realign the raster: on its rising edge, both counters load a pair of offset values.

Top module: `raster_timer`

## Requirements
- R1: While `en` is high, X advances by one per clock. After X equals the line-last register (address 1), X returns to 0 and Y advances, so a line lasts line-last + 1 clocks. After Y equals the frame-last register (address 5) at the end of a line, Y returns to 0.
- R2: `de` is high exactly when X is below the horizontal visible count (address 0) and Y is below the vertical visible count (address 4). It is aligned with the X and Y outputs in the same cycle.
- R3: Horizontal sync is active for the cycles in which X is at least the start value (address 2) and below the stop value (address 3).
- R4: Vertical sync changes only in a cycle where horizontal sync turns active. It turns active at that edge on the line where Y equals the start value (address 6), and turns inactive at that edge on the line where Y equals the stop value (address 7).
- R5: When `hs_pos` is 1, horizontal sync is active high. When it is 0, horizontal sync is active low. `vs_pos` sets the vertical sync the same way. A change of either input shows on the next clock.
- R6: While `en` is low, X, Y, `de` and the active state of both syncs keep their values.
- R7: Synchronous `rst` sets X and Y to 0 and `de` low, drives both syncs to their inactive level, and loads both the live and the staging registers with the parameter defaults.
- R8: A write stores `cfg_data` in the staging register chosen by `cfg_addr`. The live timing does not change until the next point where X and Y both wrap to 0, and from that frame on the new values apply.
- R9: A rising edge on `ext_vs`, seen on a clock with `en` high, loads X with `lock_h` and Y with `lock_v` on that clock.
- R10: Moving the sync start and stop values while the line-last and frame-last values stay the same leaves the line period and the frame period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counter advance enable |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_addr | input | AW | Staging register select |
| cfg_data | input | DW | Staging register write value |
| hs_pos | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_pos | input | 1 | Vertical sync polarity, 1 = active high |
| ext_vs | input | 1 | External frame pulse for realignment |
| lock_h | input | DW | X value loaded on realignment |
| lock_v | input | DW | Y value loaded on realignment |
| px_x | output | DW | Horizontal pixel coordinate |
| px_y | output | DW | Vertical line coordinate |
| de | output | 1 | Active-video flag |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |

## Verification
Coordinates, `de` and both syncs are due one clock after the rising edge that sampled the enable, realignment or polarity input. A register write is due at the first frame origin that follows it. The scoreboard model steps once on each rising edge and queues the output set that the requirements predict for that edge. The monitor compares the design against that entry on the falling edge that follows, so every comparison lands in the cycle in which the result is due. Directed checks measure the distance between sync leading edges in clocks, to cover the line and frame periods before and after a staged write and after the sync position is shifted.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int DW      = 14,
  parameter int AW      = 3,
  parameter int D_HACT  = 640,
  parameter int D_HLAST = 799,
  parameter int D_HSB   = 656,
  parameter int D_HSE   = 752,
  parameter int D_VACT  = 480,
  parameter int D_VLAST = 524,
  parameter int D_VSB   = 490,
  parameter int D_VSE   = 492
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          hs_pos,
  input  logic          vs_pos,
  input  logic          ext_vs,
  input  logic [DW-1:0] lock_h,
  input  logic [DW-1:0] lock_v,
  output logic [DW-1:0] px_x,
  output logic [DW-1:0] px_y,
  output logic          de,
  output logic          hsync,
  output logic          vsync
);
  localparam int NREG = 1 << AW;
  localparam int R_HACT = 0, R_HLAST = 1, R_HSB = 2, R_HSE = 3;
  localparam int R_VACT = 4, R_VLAST = 5, R_VSB = 6, R_VSE = 7;

  logic [NREG-1:0][DW-1:0] dflt, live_q, stage_q, live_n;
  logic [DW-1:0] hc, vc, hc_n, vc_n;
  logic ext_q, lock_ev, wrap, hs_a, vs_a, hs_n, vs_n, de_q, hs_q, vs_q;

  always_comb begin
    dflt          = '0;
    dflt[R_HACT]  = DW'(D_HACT);
    dflt[R_HLAST] = DW'(D_HLAST);
    dflt[R_HSB]   = DW'(D_HSB);
    dflt[R_HSE]   = DW'(D_HSE);
    dflt[R_VACT]  = DW'(D_VACT);
    dflt[R_VLAST] = DW'(D_VLAST);
    dflt[R_VSB]   = DW'(D_VSB);
    dflt[R_VSE]   = DW'(D_VSE);
  end

  assign lock_ev = en & ext_vs & ~ext_q;
  assign wrap    = en & ~lock_ev & (hc == live_q[R_HLAST]) & (vc == live_q[R_VLAST]);
  assign live_n  = wrap ? stage_q : live_q;

  always_comb begin
    hc_n = hc;
    vc_n = vc;
    if (en) begin
      if (lock_ev) begin
        hc_n = lock_h;
        vc_n = lock_v;
      end else if (hc == live_q[R_HLAST]) begin
        hc_n = '0;
        vc_n = (vc == live_q[R_VLAST]) ? '0 : vc + 1'b1;
      end else begin
        hc_n = hc + 1'b1;
      end
    end
  end

  always_comb begin
    hs_n = hs_a;
    if (en) begin
      if (hc_n == live_n[R_HSB])      hs_n = 1'b1;
      else if (hc_n == live_n[R_HSE]) hs_n = 1'b0;
    end
    vs_n = vs_a;
    if (hs_n & ~hs_a) begin
      if (vc_n == live_n[R_VSB])      vs_n = 1'b1;
      else if (vc_n == live_n[R_VSE]) vs_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= '0;
      vc      <= '0;
      ext_q   <= 1'b0;
      hs_a    <= 1'b0;
      vs_a    <= 1'b0;
      de_q    <= 1'b0;
      hs_q    <= ~hs_pos;
      vs_q    <= ~vs_pos;
      live_q  <= dflt;
      stage_q <= dflt;
    end else begin
      ext_q  <= ext_vs;
      hc     <= hc_n;
      vc     <= vc_n;
      live_q <= live_n;
      hs_a   <= hs_n;
      vs_a   <= vs_n;
      if (en) de_q <= (hc_n < live_n[R_HACT]) && (vc_n < live_n[R_VACT]);
      hs_q   <= hs_n ^ ~hs_pos;
      vs_q   <= vs_n ^ ~vs_pos;
      if (cfg_we) stage_q[cfg_addr] <= cfg_data;
    end
  end

  assign px_x  = hc;
  assign px_y  = vc;
  assign de    = de_q;
  assign hsync = hs_q;
  assign vsync = vs_q;

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    en && !lock_ev && hc == live_q[R_HLAST] |=> hc == '0);

  a_r3_hs_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    hs_a && !$past(hs_a) |-> hc == live_q[R_HSB]);

  a_r4_vs_on_hs_lead: assert property (@(posedge clk) disable iff (rst)
    vs_a != $past(vs_a) |-> hs_a && !$past(hs_a));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hc) && $stable(vc) && $stable(de_q) && $stable(hs_a) && $stable(vs_a));

  a_r8_commit_at_origin: assert property (@(posedge clk) disable iff (rst)
    live_q != $past(live_q) |-> hc == '0 && vc == '0);

  a_r9_lock_load: assert property (@(posedge clk) disable iff (rst)
    lock_ev |=> hc == $past(lock_h) && vc == $past(lock_v));
endmodule

// File: tb/raster_timer_bench.sv
module raster_timer_bench;
  localparam int DW = 14;
  typedef struct packed {
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic de, hs, vs;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0, lock_h = '0, lock_v = '0;
  logic hs_pos = 1'b0, vs_pos = 1'b0, ext_vs = 1'b0;
  logic [DW-1:0] px_x, px_y;
  logic de, hsync, vsync;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  raster_timer #(.DW(DW), .AW(3), .D_HACT(8), .D_HLAST(11), .D_HSB(9), .D_HSE(10),
                 .D_VACT(4), .D_VLAST(7), .D_VSB(5), .D_VSE(6)) u_raster_timer (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hs_pos(hs_pos), .vs_pos(vs_pos), .ext_vs(ext_vs), .lock_h(lock_h), .lock_v(lock_v),
    .px_x(px_x), .px_y(px_y), .de(de), .hsync(hsync), .vsync(vsync));

  task automatic chk(input string tag, input int act, input int exv);
    checks++;
    if (act != exv) begin
      fails++;
      if (fails < 30) $display("FAIL %s actual=%0d expected=%0d", tag, act, exv);
    end
  endtask

  logic [7:0][DW-1:0] mdef, mlive, mstage, nlive;
  logic [DW-1:0] mx, my, nx, ny;
  logic mde, mhs, mvs, mext, nhs, lk;
  initial mdef = {14'd6, 14'd5, 14'd7, 14'd4, 14'd10, 14'd9, 14'd11, 14'd8};

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      mx = '0; my = '0; mde = 0; mhs = 0; mvs = 0; mext = 0;
      mlive = mdef; mstage = mdef;
    end else begin
      lk = en && ext_vs && !mext;
      nx = mx; ny = my; nlive = mlive;
      if (en) begin
        if (lk) begin nx = lock_h; ny = lock_v; end
        else if (mx == mlive[1]) begin
          nx = '0;
          if (my == mlive[5]) begin ny = '0; nlive = mstage; end
          else ny = my + 1'b1;
        end else nx = mx + 1'b1;
        nhs = mhs;
        if (nx == nlive[2]) nhs = 1;
        else if (nx == nlive[3]) nhs = 0;
        if (nhs && !mhs) begin
          if (ny == nlive[6]) mvs = 1;
          else if (ny == nlive[7]) mvs = 0;
        end
        mde = (nx < nlive[0]) && (ny < nlive[4]);
        mhs = nhs;
      end
      if (cfg_we) mstage[cfg_addr] = cfg_data;
      mext = ext_vs; mx = nx; my = ny; mlive = nlive;
    end
    e.x = mx; e.y = my; e.de = mde;
    e.hs = mhs ^ !hs_pos; e.vs = mvs ^ !vs_pos;
    q.push_back(e);
  end

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R1 x", int'(px_x), int'(e.x));
      chk("R1 y", int'(px_y), int'(e.y));
      chk("R2 de", int'(de), int'(e.de));
      chk("R3 hsync", int'(hsync), int'(e.hs));
      chk("R4 vsync", int'(vsync), int'(e.vs));
    end
  end

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_at(input int xv, input int yv);
    forever begin
      @(negedge clk);
      if (int'(px_x) == xv && int'(px_y) == yv) break;
    end
  endtask

  task automatic lead_gap(input bit vert, output int n);
    logic p, c, act;
    act = vert ? vs_pos : hs_pos;
    p = vert ? vsync : hsync;
    c = p;
    forever begin
      @(negedge clk); c = vert ? vsync : hsync;
      if (c == act && p != act) break;
      p = c;
    end
    n = 0; p = c;
    forever begin
      @(negedge clk); n++; c = vert ? vsync : hsync;
      if (c == act && p != act) break;
      p = c;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, hx, hy, hd;
    repeat (3) @(negedge clk);
    chk("R7 reset x", int'(px_x), 0);
    chk("R7 reset y", int'(px_y), 0);
    chk("R7 reset de", int'(de), 0);
    chk("R7 reset hsync inactive", int'(hsync), 1);
    chk("R7 reset vsync inactive", int'(vsync), 1);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    lead_gap(0, n); chk("R1 line period default", n, 12);
    lead_gap(1, n); chk("R1 frame period default", n, 96);

    wait_at(0, 1);
    wr(0, 10); wr(1, 15); wr(2, 11); wr(3, 13);
    wr(4, 6);  wr(5, 9);  wr(6, 7);  wr(7, 8);
    lead_gap(0, n); chk("R8 staged not live yet", n, 12);
    wait_at(0, 0);
    lead_gap(0, n); chk("R8 new line period", n, 16);
    lead_gap(1, n); chk("R8 new frame period", n, 160);

    wait_at(0, 1);
    wr(2, 3); wr(3, 5); wr(6, 2); wr(7, 3);
    wait_at(0, 0);
    repeat (20) @(negedge clk);
    lead_gap(0, n); chk("R10 line period after shift", n, 16);
    lead_gap(1, n); chk("R10 frame period after shift", n, 160);
    wait_at(5, 2);
    chk("R4 vsync active with shifted start", int'(vsync), 0);

    wait_at(0, 0);
    hs_pos = 1'b1; vs_pos = 1'b1;
    @(negedge clk);
    chk("R5 hsync inactive low", int'(hsync), 0);
    chk("R5 vsync inactive low", int'(vsync), 0);
    wait_at(3, 0);
    chk("R5 hsync active high", int'(hsync), 1);

    wait_at(7, 4);
    en = 1'b0; hx = int'(px_x); hy = int'(px_y); hd = int'(de);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6 x frozen", int'(px_x), hx);
      chk("R6 y frozen", int'(px_y), hy);
      chk("R6 de frozen", int'(de), hd);
    end
    en = 1'b1;

    wait_at(9, 6);
    lock_h = DW'(4); lock_v = DW'(2); ext_vs = 1'b1;
    @(negedge clk);
    chk("R9 lock x", int'(px_x), 4);
    chk("R9 lock y", int'(px_y), 2);
    @(negedge clk);
    chk("R9 level held no reload", int'(px_x), 5);
    ext_vs = 1'b0;
    repeat (400) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule